// File: doc/BRIEF.md
# Coprocessor Escape Decoder with Wait Stall

This block sits on the host side of an instruction stream and sorts incoming opcode bytes into three kinds. Opcodes in the escape class belong to an attached coprocessor. The host never learns what such an instruction computes. It only decodes the addressing form from the following mode/rm byte and skips any displacement bytes. When the instruction names a memory operand, the block issues one operand read at an effective address supplied from outside. It then moves on without using the returned data.

A dedicated wait opcode stalls instruction issue for as long as the coprocessor's busy line is high. Every other opcode byte is passed through to an ordinary-instruction output, one registered cycle later. Bytes arrive over a valid/ready handshake. The decoder lowers ready whenever it is stalled, either waiting for a read grant or waiting for busy to fall.

Top module: `esc_issue_decoder`

## Requirements
- R1: An opcode byte whose upper five bits are 11011 (0xD8 to 0xDF) is an escape; `esc_valid` pulses for one cycle, in the cycle after its mode/rm byte is accepted, and no pass-through pulse is produced for either byte.
- R2: When the mode field (bits 7:6 of the mode/rm byte) is 11, `esc_mem` is 0 with `esc_valid`, no read is requested, and `in_ready` stays high for the next opcode.
- R3: When the mode field is not 11, `esc_mem` is 1 and, once any displacement has been consumed, `rd_req` rises with `rd_addr` equal to `ea_addr`; `rd_req` stays high until `rd_gnt` is seen, and `in_ready` is low while `rd_req` is high.
- R4: Displacement bytes after the mode/rm byte are consumed without classification: mode 01 takes one, mode 10 takes two, mode 00 with rm (bits 2:0) equal to 110 takes two, and any other mode 00 takes none.
- R5: The wait opcode 0x9B holds `in_ready` low while `cop_busy` is high; `in_ready` returns high in the cycle after `cop_busy` is seen low.
- R6: If `cop_busy` is already low when 0x9B is accepted, `in_ready` is low for exactly one cycle.
- R7: Any other opcode byte produces a one-cycle `pass_valid` pulse with `pass_byte` equal to that byte, in the cycle after it is accepted.
- R8: Reset drives `in_ready` high and `esc_valid`, `esc_mem`, `pass_valid` and `rd_req` low, and it discards a partially decoded instruction, so the next byte is treated as an opcode.
- R9: `rd_req` falls in the cycle after a grant, and `in_ready` returns high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| ea_addr | input | ADDR_W | Effective address of the current memory operand |
| cop_busy | input | 1 | Coprocessor busy flag |
| rd_req | output | 1 | Operand read request |
| rd_addr | output | ADDR_W | Operand read address |
| rd_gnt | input | 1 | Read request granted |
| esc_valid | output | 1 | Escape instruction decoded |
| esc_mem | output | 1 | Decoded escape has a memory operand |
| pass_valid | output | 1 | Ordinary opcode byte forwarded |
| pass_byte | output | 8 | Forwarded opcode byte |

## Verification
The hardest case to reach is a displacement byte whose value equals the wait or escape opcode. The decoder must treat that byte as plain data, which shows only as the absence of a stall or of an extra escape pulse. The stimulus feeds escape instructions with one-byte and two-byte displacements made of 0x9B and 0xD8. It then checks that `in_ready` stays high with no pulses until the read request rises. Back-pressure on the read and a reset dropped between an escape opcode and its mode/rm byte are driven directly by holding `rd_gnt` low for several cycles and by pulsing `rst_n` mid-instruction.

// File: rtl/esc_pkg.sv
package esc_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_OPC   = 3'd0,
      ST_MODRM = 3'd1,
      ST_DISP  = 3'd2,
      ST_RDREQ = 3'd3,
      ST_WAIT  = 3'd4
   } dec_state_e;

   typedef struct packed {
      logic       has_mem;
      logic [1:0] disp_len;
   } modrm_info_t;
endpackage

// File: rtl/esc_opcode_class.sv
module esc_opcode_class #(
   parameter logic [7:0] ESC_MASK  = 8'hF8,
   parameter logic [7:0] ESC_MATCH = 8'hD8,
   parameter logic [7:0] WAIT_OPC  = 8'h9B
) (
   input  logic [7:0] opc,
   output logic       is_esc,
   output logic       is_wait
);
   if ((ESC_MATCH & ~ESC_MASK) != 8'h00) begin : g_bad_match
      $error("ESC_MATCH has bits outside ESC_MASK");
   end
   if ((WAIT_OPC & ESC_MASK) == ESC_MATCH) begin : g_bad_wait
      $error("WAIT_OPC overlaps the escape class");
   end

   always_comb begin
      is_esc  = ((opc & ESC_MASK) == ESC_MATCH);
      is_wait = (opc == WAIT_OPC);
   end
endmodule

// File: rtl/esc_modrm_info.sv
module esc_modrm_info
   import esc_pkg::*;
#(
   parameter bit DIRECT_DISP = 1'b1
) (
   input  logic [7:0]  modrm,
   output modrm_info_t info
);
   logic [1:0] mode_f;
   logic [2:0] rm_f;
   logic       direct_hit;

   assign mode_f = modrm[7:6];
   assign rm_f   = modrm[2:0];

   if (DIRECT_DISP) begin : g_direct
      assign direct_hit = (mode_f == 2'b00) && (rm_f == 3'b110);
   end else begin : g_nodirect
      assign direct_hit = 1'b0;
   end

   always_comb begin
      info.has_mem = (mode_f != 2'b11);
      unique case (mode_f)
         2'b01:   info.disp_len = 2'd1;
         2'b10:   info.disp_len = 2'd2;
         2'b00:   info.disp_len = direct_hit ? 2'd2 : 2'd0;
         default: info.disp_len = 2'd0;
      endcase
   end
endmodule

// File: rtl/esc_pass_stage.sv
module esc_pass_stage #(
   parameter int DATA_W = 8,
   parameter int STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_v,
   input  logic [DATA_W-1:0] in_d,
   output logic              out_v,
   output logic [DATA_W-1:0] out_d
);
   if (STAGES < 1) begin : g_bad_stages
      $error("STAGES must be at least 1");
   end

   logic              v_q [STAGES];
   logic [DATA_W-1:0] d_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic              v_in;
      logic [DATA_W-1:0] d_in;
      if (i == 0) begin : g_head
         assign v_in = in_v;
         assign d_in = in_d;
      end else begin : g_tail
         assign v_in = v_q[i-1];
         assign d_in = d_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q[i] <= 1'b0;
            d_q[i] <= '0;
         end else begin
            v_q[i] <= v_in;
            d_q[i] <= v_in ? d_in : '0;
         end
      end
   end

   assign out_v = v_q[STAGES-1];
   assign out_d = d_q[STAGES-1];
endmodule

// File: rtl/esc_issue_decoder.sv
module esc_issue_decoder
   import esc_pkg::*;
#(
   parameter int         ADDR_W      = 20,
   parameter logic [7:0] ESC_MASK    = 8'hF8,
   parameter logic [7:0] ESC_MATCH   = 8'hD8,
   parameter logic [7:0] WAIT_OPC    = 8'h9B,
   parameter bit         DIRECT_DISP = 1'b1,
   parameter int         PASS_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] ea_addr,
   input  logic              cop_busy,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_gnt,
   output logic              esc_valid,
   output logic              esc_mem,
   output logic              pass_valid,
   output logic [7:0]        pass_byte
);
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   dec_state_e  state;
   logic [1:0]  disp_left;
   logic        esc_valid_q, esc_mem_q;
   logic        take, is_esc, is_wait, pass_in;
   modrm_info_t mi;

   esc_opcode_class #(
      .ESC_MASK (ESC_MASK),
      .ESC_MATCH(ESC_MATCH),
      .WAIT_OPC (WAIT_OPC)
   ) u_class (
      .opc    (in_byte),
      .is_esc (is_esc),
      .is_wait(is_wait)
   );

   esc_modrm_info #(.DIRECT_DISP(DIRECT_DISP)) u_modrm (
      .modrm(in_byte),
      .info (mi)
   );

   assign in_ready = (state == ST_OPC) || (state == ST_MODRM) || (state == ST_DISP);
   assign take     = in_valid && in_ready;
   assign pass_in  = take && (state == ST_OPC) && !is_esc && !is_wait;

   esc_pass_stage #(.DATA_W(BYTE_W), .STAGES(PASS_STAGES)) u_pass (
      .clk  (clk),
      .rst_n(rst_n),
      .in_v (pass_in),
      .in_d (in_byte),
      .out_v(pass_valid),
      .out_d(pass_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_OPC;
         disp_left   <= 2'd0;
         esc_valid_q <= 1'b0;
         esc_mem_q   <= 1'b0;
      end else begin
         esc_valid_q <= 1'b0;
         esc_mem_q   <= 1'b0;
         unique case (state)
            ST_OPC: begin
               if (take && is_esc)       state <= ST_MODRM;
               else if (take && is_wait) state <= ST_WAIT;
            end
            ST_MODRM: begin
               if (take) begin
                  esc_valid_q <= 1'b1;
                  esc_mem_q   <= mi.has_mem;
                  if (!mi.has_mem) begin
                     state <= ST_OPC;
                  end else if (mi.disp_len != 2'd0) begin
                     disp_left <= mi.disp_len;
                     state     <= ST_DISP;
                  end else begin
                     state <= ST_RDREQ;
                  end
               end
            end
            ST_DISP: begin
               if (take) begin
                  disp_left <= disp_left - 2'd1;
                  if (disp_left == 2'd1) state <= ST_RDREQ;
               end
            end
            ST_RDREQ: if (rd_gnt)    state <= ST_OPC;
            ST_WAIT:  if (!cop_busy) state <= ST_OPC;
            default:  state <= ST_OPC;
         endcase
      end
   end

   assign rd_req    = (state == ST_RDREQ);
   assign rd_addr   = rd_req ? ea_addr : '0;
   assign esc_valid = esc_valid_q;
   assign esc_mem   = esc_mem_q;
endmodule

// File: rtl/esc_issue_checker.sv
module esc_issue_checker (
   input logic clk,
   input logic rst_n,
   input logic in_ready,
   input logic rd_req,
   input logic rd_gnt,
   input logic esc_valid,
   input logic esc_mem,
   input logic pass_valid
);
   assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_gnt) |=> rd_req);

   assert_stall_on_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !in_ready);

   assert_rd_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_gnt) |=> (!rd_req && in_ready));

   assert_no_dual_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(esc_valid && pass_valid));

   assert_mem_flag_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
      esc_mem |-> esc_valid);
endmodule

bind esc_issue_decoder esc_issue_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .rd_req    (rd_req),
   .rd_gnt    (rd_gnt),
   .esc_valid (esc_valid),
   .esc_mem   (esc_mem),
   .pass_valid(pass_valid)
);

// File: tb/tb_esc_issue_decoder.sv
`timescale 1ns/1ps
module tb_esc_issue_decoder;
   localparam int ADDR_W = 20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [7:0]        in_byte = 8'h00;
   logic              in_ready;
   logic [ADDR_W-1:0] ea_addr = '0;
   logic              cop_busy = 1'b0;
   logic              rd_req;
   logic [ADDR_W-1:0] rd_addr;
   logic              rd_gnt = 1'b0;
   logic              esc_valid, esc_mem, pass_valid;
   logic [7:0]        pass_byte;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   esc_issue_decoder #(.ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .ea_addr(ea_addr), .cop_busy(cop_busy),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
      .esc_valid(esc_valid), .esc_mem(esc_mem),
      .pass_valid(pass_valid), .pass_byte(pass_byte)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Offer one byte; returns at the falling edge after the accepting edge.
   task automatic push(input logic [7:0] b);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic grant_after(input int hold, input string req);
      for (int i = 0; i < hold; i++) begin
         check(req, "rd_req held", rd_req, 1);
         check(req, "in_ready low during read", in_ready, 0);
         @(negedge clk);
      end
      rd_gnt = 1'b1;
      @(negedge clk);
      rd_gnt = 1'b0;
      check("R9", "rd_req dropped after grant", rd_req, 0);
      check("R9", "in_ready back after grant", in_ready, 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R8", "in_ready at reset", in_ready, 1);
      check("R8", "esc_valid at reset", esc_valid, 0);
      check("R8", "esc_mem at reset", esc_mem, 0);
      check("R8", "pass_valid at reset", pass_valid, 0);
      check("R8", "rd_req at reset", rd_req, 0);
   endtask

   task automatic t_pass();
      push(8'h90);
      check("R7", "pass_valid 0x90", pass_valid, 1);
      check("R7", "pass_byte 0x90", pass_byte, 8'h90);
      check("R7", "no escape on 0x90", esc_valid, 0);
      push(8'h8B);
      check("R7", "pass_byte 0x8B", pass_byte, 8'h8B);
      @(negedge clk);
      check("R7", "pass pulse one cycle", pass_valid, 0);
   endtask

   task automatic t_esc_reg();
      push(8'hD9);
      check("R1", "no pass on escape opcode", pass_valid, 0);
      check("R1", "no esc before modrm", esc_valid, 0);
      push(8'hC1);
      check("R1", "esc_valid after modrm", esc_valid, 1);
      check("R2", "esc_mem for mode 11", esc_mem, 0);
      check("R2", "no read for mode 11", rd_req, 0);
      check("R2", "ready after mode 11", in_ready, 1);
      check("R1", "no pass on modrm", pass_valid, 0);
      @(negedge clk);
      check("R1", "esc pulse one cycle", esc_valid, 0);
   endtask

   task automatic t_esc_mem_nodisp();
      ea_addr = 20'hABCDE;
      push(8'hDF);
      push(8'h07);
      check("R1", "esc_valid mode 00", esc_valid, 1);
      check("R3", "esc_mem mode 00", esc_mem, 1);
      check("R4", "no disp for mode 00 rm 111", rd_req, 1);
      check("R3", "rd_addr", rd_addr, 20'hABCDE);
      grant_after(3, "R3");
   endtask

   task automatic t_disp1();
      ea_addr = 20'h01234;
      push(8'hDD);
      push(8'h46);
      check("R3", "esc_mem mode 01", esc_mem, 1);
      check("R4", "no read before disp", rd_req, 0);
      check("R4", "ready for disp byte", in_ready, 1);
      push(8'h9B);
      check("R4", "wait-valued disp not stalling", rd_req, 1);
      check("R4", "wait-valued disp not passed", pass_valid, 0);
      check("R3", "rd_addr mode 01", rd_addr, 20'h01234);
      grant_after(1, "R3");
   endtask

   task automatic t_disp2();
      ea_addr = 20'hF00F0;
      push(8'hDC);
      push(8'h86);
      push(8'hD8);
      check("R4", "escape-valued disp no esc", esc_valid, 0);
      check("R4", "still consuming disp mode 10", rd_req, 0);
      push(8'h9B);
      check("R4", "read after two disp bytes", rd_req, 1);
      check("R3", "rd_addr mode 10", rd_addr, 20'hF00F0);
      grant_after(2, "R3");
      push(8'h90);
      check("R4", "opcode after disp is opcode", pass_valid, 1);
   endtask

   task automatic t_direct();
      ea_addr = 20'h00042;
      push(8'hD8);
      push(8'h06);
      check("R4", "mode 00 rm 110 waits disp", rd_req, 0);
      push(8'h34);
      check("R4", "one of two disp", rd_req, 0);
      push(8'h12);
      check("R4", "read after direct disp", rd_req, 1);
      grant_after(0, "R3");
   endtask

   task automatic t_wait_free();
      cop_busy = 1'b0;
      push(8'h9B);
      check("R6", "stall cycle", in_ready, 0);
      check("R6", "wait not passed", pass_valid, 0);
      @(negedge clk);
      check("R6", "ready after one cycle", in_ready, 1);
   endtask

   task automatic t_wait_busy();
      cop_busy = 1'b1;
      push(8'h9B);
      for (int i = 0; i < 4; i++) begin
         check("R5", "stalled while busy", in_ready, 0);
         @(negedge clk);
      end
      cop_busy = 1'b0;
      @(negedge clk);
      check("R5", "ready after busy low", in_ready, 1);
   endtask

   task automatic t_reset_mid();
      push(8'hDA);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      push(8'h46);
      check("R8", "byte after reset is opcode", pass_valid, 1);
      check("R8", "pass byte after reset", pass_byte, 8'h46);
      check("R8", "no escape after reset", esc_valid, 0);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_pass();
      t_esc_reg();
      t_esc_mem_nodisp();
      t_disp1();
      t_disp2();
      t_direct();
      t_wait_free();
      t_wait_busy();
      t_reset_mid();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule